// File: doc/BRIEF.md
# Standby and Operating-Mode Sequencer

This block decides, cycle by cycle, which clocks a small 8-bit microcontroller may use. It comes out of reset in the plain run state. In that state the processor and the peripherals both run from the fast clock. Software moves the block between run and standby states with two write strobes:

- An idle request stops the processor but keeps the peripherals clocked. Any pending interrupt ends it.
- A halt request stops everything except the time-base timer. Only a falling edge of the selected time-base source clock ends it.

When the block wakes, it sends a one-cycle wake strobe and a resume type. The resume type tells the processor either to vector to the interrupt or to continue with the next instruction. On the way out of the deep standby state, the block can also ask for the time-base interrupt latch to be set.

Software can also turn on the dual-clock modes once the slow oscillator is running. These are:

- a dual run state, with the processor on the fast clock and the peripherals on both clocks;
- a slow run state, with everything on the slow clock.

Each of these has its own idle counterpart. Reset always returns the block to single-clock operation. The oscillators, the processor and the peripherals sit outside this block. It drives only their enables and the main-clock select.

Top module: `opmode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in the single-clock run state: cpu_clk_en=1, periph_clk_en=1, lf_periph_en=0, main_clk_low=0, wake=0, tbt_irq_set=0, idle_bit=0, halt_bit=0.
- R2: A wr_idle strobe in the single-clock run state enters peripheral-idle at the next clock edge: cpu_clk_en=0, periph_clk_en=1, idle_bit=1.
- R3: In any idle state, a nonzero irq_req returns the block, at the next edge, to the run state it came from. At that edge the block clears idle_bit, sets cpu_clk_en=1 and raises wake with resume_vec equal to ime (1 = vector to interrupt, 0 = continue).
- R4: A wr_halt strobe in the single-clock run state enters deep standby at the next edge: cpu_clk_en=0, periph_clk_en=0, halt_bit=1.
- R5: In deep standby, irq_req, rising edges and unselected sources have no effect. A falling edge on tb_src[tb_sel] passes two synchronizer flops and one edge flop. Wake therefore shows after the third clock edge following the fall, and the block is back in the single-clock run state with halt_bit=0.
- R6: Deep standby ends on the selected edge whatever tbt_en is. resume_vec is then ime AND tbt_ie AND tbt_en.
- R7: tbt_irq_set pulses together with the deep-standby wake if and only if tbt_en was 1 in the cycle the halt strobe was taken.
- R8: If wr_idle and wr_halt arrive together in the single-clock run state, deep standby is entered and idle_bit stays 0.
- R9: The dual run state is entered from single-clock run only when dual_sel=1 and lf_osc_on=1. It shows lf_periph_en=1 and main_clk_low=0. slow_sel=1 there enters slow run, with main_clk_low=1. Clearing slow_sel returns to dual run, and clearing dual_sel returns to single-clock run.
- R10: wr_idle in dual run enters dual idle (cpu_clk_en=0, lf_periph_en=1, main_clk_low=0). wr_idle in slow run enters slow sleep (cpu_clk_en=0, main_clk_low=1).
- R11: A wr_halt strobe outside the single-clock run state is ignored: the state is unchanged and halt_bit stays 0.
- R12: wake and tbt_irq_set are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (fast clock domain) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_idle | input | 1 | One-cycle strobe: software requests idle |
| wr_halt | input | 1 | One-cycle strobe: software requests deep standby |
| dual_sel | input | 1 | Control level: use the dual-clock modes |
| slow_sel | input | 1 | Control level: run from the slow clock |
| lf_osc_on | input | 1 | Slow oscillator has been enabled by software |
| irq_req | input | N_IRQ | Enabled interrupt requests |
| ime | input | 1 | Master interrupt enable |
| tbt_en | input | 1 | Time-base timer enable |
| tbt_ie | input | 1 | Time-base interrupt enable |
| tb_src | input | N_TBSRC | Candidate time-base source clocks |
| tb_sel | input | SELW | Index of the time-base source that ends deep standby |
| cpu_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| lf_periph_en | output | 1 | Peripherals also receive the slow clock |
| main_clk_low | output | 1 | Main clock taken from the slow oscillator |
| wake | output | 1 | One-cycle strobe: standby has ended |
| resume_vec | output | 1 | With wake: 1 vector to interrupt, 0 continue |
| tbt_irq_set | output | 1 | One-cycle strobe: set the time-base interrupt latch |
| idle_bit | output | 1 | Idle request bit, self-clearing on wake |
| halt_bit | output | 1 | Halt request bit, self-clearing on wake |

## Verification
The properties assume that the write strobes arrive only while the processor runs. That means wr_idle and wr_halt are never raised while cpu_clk_en is 0, and each lasts a single cycle. They also assume that tb_sel holds steady during deep standby. Switching the selected source could otherwise show a falling edge that no single source produced. The stimulus drives every strobe for exactly one cycle from a run state, changes tb_sel only while the block is running, and moves the time-base sources only on the falling clock edge, well clear of the synchronizer sampling point.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

  typedef enum logic [2:0] {
    MD_RUN_HI    = 3'd0,
    MD_IDLE_PERI = 3'd1,
    MD_IDLE_TB   = 3'd2,
    MD_RUN_DUAL  = 3'd3,
    MD_IDLE_DUAL = 3'd4,
    MD_RUN_LO    = 3'd5,
    MD_SLEEP_LO  = 3'd6
  } opmode_e;

  typedef struct packed {
    logic cpu_en;
    logic periph_en;
    logic lf_periph;
    logic clk_low;
  } clk_ctl_t;

endpackage

// File: rtl/opm_rst_sync.sv
module opm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/opm_tb_fall.sv
module opm_tb_fall #(
  parameter int N_SRC       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SELW       = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src,
  input  logic [SELW-1:0]  sel,
  output logic             fall
);

  logic [N_SRC-1:0] synced;
  logic             cur;
  logic             prev_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
      end else begin
        sh_q <= {sh_q[SYNC_STAGES-2:0], src[i]};
      end
    end
    assign synced[i] = sh_q[SYNC_STAGES-1];
  end

  always_comb begin
    cur = 1'b1;
    for (int k = 0; k < N_SRC; k++) begin
      if (sel == SELW'(k)) cur = synced[k];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= cur;
    end
  end

  assign fall = prev_q & ~cur;

endmodule

// File: rtl/opm_mode_fsm.sv
module opm_mode_fsm
  import opmode_pkg::*;
(
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    wr_idle,
  input  logic    wr_halt,
  input  logic    dual_sel,
  input  logic    slow_sel,
  input  logic    lf_osc_on,
  input  logic    irq_any,
  input  logic    ime,
  input  logic    tbt_en,
  input  logic    tbt_ie,
  input  logic    tb_fall,
  output opmode_e mode,
  output logic    idle_bit,
  output logic    halt_bit,
  output logic    wake,
  output logic    resume_vec,
  output logic    tbt_irq_set
);

  opmode_e mode_q, mode_d;
  logic    idle_q, idle_d;
  logic    halt_q, halt_d;
  logic    tben_q, tben_d;
  logic    wake_q, wake_d;
  logic    resume_q, resume_d;
  logic    tbset_q, tbset_d;

  always_comb begin
    mode_d   = mode_q;
    idle_d   = idle_q;
    halt_d   = halt_q;
    tben_d   = tben_q;
    wake_d   = 1'b0;
    resume_d = 1'b0;
    tbset_d  = 1'b0;
    unique case (mode_q)
      MD_RUN_HI: begin
        if (wr_halt) begin
          mode_d = MD_IDLE_TB;
          halt_d = 1'b1;
          tben_d = tbt_en;
        end else if (wr_idle) begin
          mode_d = MD_IDLE_PERI;
          idle_d = 1'b1;
        end else if (dual_sel && lf_osc_on) begin
          mode_d = MD_RUN_DUAL;
        end
      end
      MD_RUN_DUAL: begin
        if (wr_idle) begin
          mode_d = MD_IDLE_DUAL;
          idle_d = 1'b1;
        end else if (!dual_sel) begin
          mode_d = MD_RUN_HI;
        end else if (slow_sel) begin
          mode_d = MD_RUN_LO;
        end
      end
      MD_RUN_LO: begin
        if (wr_idle) begin
          mode_d = MD_SLEEP_LO;
          idle_d = 1'b1;
        end else if (!slow_sel) begin
          mode_d = MD_RUN_DUAL;
        end
      end
      MD_IDLE_PERI, MD_IDLE_DUAL, MD_SLEEP_LO: begin
        if (irq_any) begin
          idle_d   = 1'b0;
          wake_d   = 1'b1;
          resume_d = ime;
          if (mode_q == MD_IDLE_PERI)      mode_d = MD_RUN_HI;
          else if (mode_q == MD_IDLE_DUAL) mode_d = MD_RUN_DUAL;
          else                             mode_d = MD_RUN_LO;
        end
      end
      MD_IDLE_TB: begin
        if (tb_fall) begin
          mode_d   = MD_RUN_HI;
          halt_d   = 1'b0;
          wake_d   = 1'b1;
          resume_d = ime & tbt_ie & tbt_en;
          tbset_d  = tben_q;
        end
      end
      default: begin
        mode_d = MD_RUN_HI;
        idle_d = 1'b0;
        halt_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MD_RUN_HI;
      idle_q   <= 1'b0;
      halt_q   <= 1'b0;
      tben_q   <= 1'b0;
      wake_q   <= 1'b0;
      resume_q <= 1'b0;
      tbset_q  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      idle_q   <= idle_d;
      halt_q   <= halt_d;
      tben_q   <= tben_d;
      wake_q   <= wake_d;
      resume_q <= resume_d;
      tbset_q  <= tbset_d;
    end
  end

  assign mode        = mode_q;
  assign idle_bit    = idle_q;
  assign halt_bit    = halt_q;
  assign wake        = wake_q;
  assign resume_vec  = resume_q;
  assign tbt_irq_set = tbset_q;

endmodule

// File: rtl/opm_out_decode.sv
module opm_out_decode
  import opmode_pkg::*;
(
  input  opmode_e  mode,
  output clk_ctl_t ctl
);

  always_comb begin
    ctl = '{cpu_en: 1'b1, periph_en: 1'b1, lf_periph: 1'b0, clk_low: 1'b0};
    unique case (mode)
      MD_RUN_HI:    ctl = '{cpu_en: 1'b1, periph_en: 1'b1, lf_periph: 1'b0, clk_low: 1'b0};
      MD_IDLE_PERI: ctl = '{cpu_en: 1'b0, periph_en: 1'b1, lf_periph: 1'b0, clk_low: 1'b0};
      MD_IDLE_TB:   ctl = '{cpu_en: 1'b0, periph_en: 1'b0, lf_periph: 1'b0, clk_low: 1'b0};
      MD_RUN_DUAL:  ctl = '{cpu_en: 1'b1, periph_en: 1'b1, lf_periph: 1'b1, clk_low: 1'b0};
      MD_IDLE_DUAL: ctl = '{cpu_en: 1'b0, periph_en: 1'b1, lf_periph: 1'b1, clk_low: 1'b0};
      MD_RUN_LO:    ctl = '{cpu_en: 1'b1, periph_en: 1'b1, lf_periph: 1'b1, clk_low: 1'b1};
      MD_SLEEP_LO:  ctl = '{cpu_en: 1'b0, periph_en: 1'b1, lf_periph: 1'b1, clk_low: 1'b1};
      default:      ctl = '{cpu_en: 1'b1, periph_en: 1'b1, lf_periph: 1'b0, clk_low: 1'b0};
    endcase
  end

endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
  import opmode_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int N_TBSRC     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int SELW       = (N_TBSRC > 1) ? $clog2(N_TBSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_idle,
  input  logic               wr_halt,
  input  logic               dual_sel,
  input  logic               slow_sel,
  input  logic               lf_osc_on,
  input  logic [N_IRQ-1:0]   irq_req,
  input  logic               ime,
  input  logic               tbt_en,
  input  logic               tbt_ie,
  input  logic [N_TBSRC-1:0] tb_src,
  input  logic [SELW-1:0]    tb_sel,
  output logic               cpu_clk_en,
  output logic               periph_clk_en,
  output logic               lf_periph_en,
  output logic               main_clk_low,
  output logic               wake,
  output logic               resume_vec,
  output logic               tbt_irq_set,
  output logic               idle_bit,
  output logic               halt_bit
);

  logic     rst_ni;
  logic     tb_fall;
  opmode_e  mode;
  clk_ctl_t ctl;

  opm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_ni)
  );

  opm_tb_fall #(.N_SRC(N_TBSRC), .SYNC_STAGES(SYNC_STAGES)) u_fall (
    .clk    (clk),
    .rst_ni (rst_ni),
    .src    (tb_src),
    .sel    (tb_sel),
    .fall   (tb_fall)
  );

  opm_mode_fsm u_fsm (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .wr_idle     (wr_idle),
    .wr_halt     (wr_halt),
    .dual_sel    (dual_sel),
    .slow_sel    (slow_sel),
    .lf_osc_on   (lf_osc_on),
    .irq_any     (|irq_req),
    .ime         (ime),
    .tbt_en      (tbt_en),
    .tbt_ie      (tbt_ie),
    .tb_fall     (tb_fall),
    .mode        (mode),
    .idle_bit    (idle_bit),
    .halt_bit    (halt_bit),
    .wake        (wake),
    .resume_vec  (resume_vec),
    .tbt_irq_set (tbt_irq_set)
  );

  opm_out_decode u_dec (
    .mode (mode),
    .ctl  (ctl)
  );

  assign cpu_clk_en    = ctl.cpu_en;
  assign periph_clk_en = ctl.periph_en;
  assign lf_periph_en  = ctl.lf_periph;
  assign main_clk_low  = ctl.clk_low;

endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic ime,
  input logic tbt_en,
  input logic tbt_ie,
  input logic cpu_clk_en,
  input logic periph_clk_en,
  input logic lf_periph_en,
  input logic main_clk_low,
  input logic wake,
  input logic resume_vec,
  input logic tbt_irq_set,
  input logic idle_bit,
  input logic halt_bit
);

  assert_idle_gates_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_bit |-> (!cpu_clk_en && periph_clk_en));

  assert_wake_runs_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (cpu_clk_en && !idle_bit && !halt_bit));

  assert_halt_gates_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    halt_bit |-> (!cpu_clk_en && !periph_clk_en));

  assert_tb_resume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && $past(halt_bit)) |-> (resume_vec == $past(ime && tbt_ie && tbt_en)));

  assert_latch_only_on_tb_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbt_irq_set |-> (wake && $past(halt_bit)));

  assert_one_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle_bit && halt_bit));

  assert_slow_is_dual_R9: assert property (@(posedge clk) disable iff (!rst_n)
    main_clk_low |-> lf_periph_en);

  assert_wake_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

endmodule

bind opmode_ctrl opmode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ime           (ime),
  .tbt_en        (tbt_en),
  .tbt_ie        (tbt_ie),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .lf_periph_en  (lf_periph_en),
  .main_clk_low  (main_clk_low),
  .wake          (wake),
  .resume_vec    (resume_vec),
  .tbt_irq_set   (tbt_irq_set),
  .idle_bit      (idle_bit),
  .halt_bit      (halt_bit)
);

// File: tb/tb_opmode_ctrl.sv
module tb_opmode_ctrl;

  localparam int N_IRQ   = 4;
  localparam int N_TBSRC = 4;
  localparam int SELW    = 2;
  localparam int NROWS   = 19;

  logic clk, rst_n, wr_idle, wr_halt, dual_sel, slow_sel, lf_osc_on;
  logic [N_IRQ-1:0]   irq_req;
  logic ime, tbt_en, tbt_ie;
  logic [N_TBSRC-1:0] tb_src;
  logic [SELW-1:0]    tb_sel;
  logic cpu_clk_en, periph_clk_en, lf_periph_en, main_clk_low;
  logic wake, resume_vec, tbt_irq_set, idle_bit, halt_bit;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;

  opmode_ctrl #(.N_IRQ(N_IRQ), .N_TBSRC(N_TBSRC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_idle(wr_idle), .wr_halt(wr_halt),
    .dual_sel(dual_sel), .slow_sel(slow_sel), .lf_osc_on(lf_osc_on),
    .irq_req(irq_req), .ime(ime), .tbt_en(tbt_en), .tbt_ie(tbt_ie),
    .tb_src(tb_src), .tb_sel(tb_sel), .cpu_clk_en(cpu_clk_en),
    .periph_clk_en(periph_clk_en), .lf_periph_en(lf_periph_en),
    .main_clk_low(main_clk_low), .wake(wake), .resume_vec(resume_vec),
    .tbt_irq_set(tbt_irq_set), .idle_bit(idle_bit), .halt_bit(halt_bit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Row: [19:16] requirement number, [15:8] stimulus
  // {wr_idle, wr_halt, dual_sel, slow_sel, lf_osc_on, ime, irq_hi, irq_lo},
  // [7:0] expected {cpu, periph, lf_periph, clk_low, wake, resume, idle, halt}.
  localparam logic [19:0] TBL [NROWS] = '{
    20'h1_00_C0,  // R1 run state after reset
    20'h2_80_42,  // R2 idle request
    20'h2_00_42,  // R2 stays idle
    20'h3_05_CC,  // R3 irq with ime=1 -> vector
    20'hC_00_C0,  // R12 wake lasted one cycle
    20'h2_80_42,  // R2 idle again
    20'h3_02_C8,  // R3 irq with ime=0 -> continue
    20'h9_20_C0,  // R9 dual without oscillator: no change
    20'h9_28_E0,  // R9 dual run
    20'hB_68_E0,  // R11 halt ignored in dual run
    20'h9_38_F0,  // R9 slow run
    20'hA_B8_72,  // R10 slow sleep
    20'hA_3D_FC,  // R10 wake back to slow run
    20'h9_28_E0,  // R9 slow cleared -> dual run
    20'hA_A8_62,  // R10 dual idle
    20'hA_2A_E8,  // R10 wake back to dual run
    20'h9_08_C0,  // R9 dual cleared -> single run
    20'h8_C0_01,  // R8 both writes -> deep standby
    20'h5_05_01   // R5 interrupt ignored in deep standby
  };

  function automatic logic [7:0] obs();
    return {cpu_clk_en, periph_clk_en, lf_periph_en, main_clk_low,
            wake, resume_vec, idle_bit, halt_bit};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_idle = 0; wr_halt = 0; dual_sel = 0; slow_sel = 0;
    lf_osc_on = 0; irq_req = '0; ime = 0; tbt_en = 0; tbt_ie = 0;
    tb_src = '1; tb_sel = 2'd1;
    repeat (3) @(negedge clk);
    chk("R1 during reset", obs(), 8'hC0);
    chk("R1 tbt_irq_set in reset", {7'd0, tbt_irq_set}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      {wr_idle, wr_halt, dual_sel, slow_sel, lf_osc_on, ime} = TBL[r][15:10];
      irq_req = {TBL[r][9], {(N_IRQ-2){1'b0}}, TBL[r][8]};
      @(negedge clk);
      n_checks++;
      if (obs() !== TBL[r][7:0]) begin
        n_fail++;
        $display("FAIL R%0d table row %0d: actual %h expected %h",
                 TBL[r][19:16], r, obs(), TBL[r][7:0]);
      end
    end

    // Deep standby entered with tbt_en=0: unselected and exact-latency checks (R5, R6, R7)
    wr_idle = 0; wr_halt = 0; dual_sel = 0; slow_sel = 0; irq_req = '0;
    ime = 1; tbt_ie = 1; tbt_en = 1; tb_src[0] = 1'b0;
    repeat (5) @(negedge clk);
    chk("R5 unselected source fall ignored", obs(), 8'h01);
    tb_src[0] = 1'b1;
    repeat (3) @(negedge clk);
    tb_src[1] = 1'b0;
    @(negedge clk);
    chk("R5 first edge after fall", obs(), 8'h01);
    @(negedge clk);
    chk("R5 second edge after fall", obs(), 8'h01);
    @(negedge clk);
    chk("R6 wake after third edge, vectored", obs(), 8'hCC);
    chk("R7 no latch set when entered with tbt_en=0", {7'd0, tbt_irq_set}, 8'h00);
    @(negedge clk);
    chk("R12 wake dropped", obs(), 8'hC0);

    // Deep standby entered with tbt_en=1, woken with tbt_en=0
    tbt_en = 1; tbt_ie = 0; wr_halt = 1;
    @(negedge clk);
    wr_halt = 0;
    chk("R4 deep standby entered", obs(), 8'h01);
    tb_src[1] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 rising edge ignored", obs(), 8'h01);
    tbt_en = 0; tb_src[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 not yet awake", obs(), 8'h01);
    @(negedge clk);
    chk("R6 wake with tbt_en=0, sequential resume", obs(), 8'hC8);
    chk("R7 latch set on wake", {7'd0, tbt_irq_set}, 8'h01);
    @(negedge clk);
    chk("R12 latch set single cycle", {7'd0, tbt_irq_set}, 8'h00);

    // Asynchronous reset taken from idle (R1)
    wr_idle = 1;
    @(negedge clk);
    wr_idle = 0;
    chk("R2 idle before reset", obs(), 8'h42);
    #5 rst_n = 1'b0;
    #1;
    chk("R1 async reset from idle", obs(), 8'hC0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 run state after release", obs(), 8'hC0);

    done = 1;
    summary();
    $finish;
  end

endmodule